// File: doc/BRIEF.md
# Handshake-Driven Step Sequencer with Fork-Join

This controller runs a fixed program of control steps, one after another. Each step names one or more sub-units. When the step becomes current, the controller raises the go line of every sub-unit in that step. It then waits for each of those sub-units to answer on its done line. The controller makes no assumption about how many cycles any sub-unit takes. It moves to the next step only when every member of the current step has answered, so a step with several members behaves as a fork followed by a join.

Which sub-units belong to which step is fixed at elaboration by a packed membership parameter. The membership word of step k sits at bits [k*NUM_UNITS +: NUM_UNITS], and bit u of that word places sub-unit u in step k.

While the caller holds the top-level start line high, the program runs. After the last step the controller reports completion and holds there. When the caller lowers start, the controller is re-armed at step 0.

Top module: `hs_seq_ctrl`

## Requirements
- R1: After reset the index is 0 and no completion is recorded. The first cycle with `seq_go` high asserts `unit_go` for exactly the members of step 0.
- R2: While `seq_go` is high and step k is current, `unit_go[u]` is high exactly for the members u of step k that have not yet recorded a done. All other `unit_go` bits are low.
- R3: The index holds its value for any number of cycles, for as long as the current step has not finished.
- R4: A step with several members finishes only once every member has signalled done. Done pulses from different members that arrive in different cycles are all counted.
- R5: A member whose done is sampled high while the step is still waiting on other members has its `unit_go` low from the next cycle on.
- R6: In a cycle where the last missing done of step k arrives, the index becomes k+1 at the clock edge. From the next cycle on, `unit_go` shows the members of step k+1, and no completion is carried over.
- R7: After the last step finishes, the index holds the terminal value NUM_STEPS. While `seq_go` stays high, `seq_done` is high and every `unit_go` bit is low.
- R8: While `seq_go` is low, all outputs are low and the index returns to 0 at the next clock. Raising `seq_go` again restarts the program at step 0.
- R9: A done from a sub-unit that is not a member of the current step has no effect on the index or on any completion record.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| seq_go | input | 1 | Top-level start; held high while the program should run |
| unit_done | input | NUM_UNITS | Completion handshake from each sub-unit |
| unit_go | output | NUM_UNITS | Activation to each sub-unit |
| seq_done | output | 1 | High while the terminal state is held and `seq_go` is high |

## Verification
Two events can fall in the same cycle. The first is the last missing done of a join. The second is an earlier member's done that was already recorded, or a done from a non-member. In that cycle the controller must both close the step and drop every completion record. The bench provokes this with directed steps: in one step both members finish in the same cycle, and in another a non-member's done arrives alongside a member's done. Random done patterns then keep colliding joins with stray pulses. Every cycle, the bench judges `unit_go` and `seq_done` against a behavioural model of the step index and the recorded completions.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;
  // Largest program the controller is meant to run.
  localparam int unsigned MAX_STEPS = 8;
  // Width of an index that can hold 0..steps (terminal included).
  function automatic int unsigned idx_width(input int unsigned steps);
    return (steps < 1) ? 1 : $clog2(steps + 1);
  endfunction
endpackage

// File: rtl/seq_step_decode.sv
module seq_step_decode #(
  parameter int unsigned NUM_STEPS = 4,
  parameter int unsigned NUM_UNITS = 4,
  parameter int unsigned IDX_W     = 3,
  parameter logic [NUM_STEPS*NUM_UNITS-1:0] STEP_MAP = '0
) (
  input  logic [IDX_W-1:0]     idx,
  output logic [NUM_UNITS-1:0] member,
  output logic                 in_prog
);
  logic [NUM_UNITS-1:0] row [NUM_STEPS];

  for (genvar k = 0; k < NUM_STEPS; k++) begin : g_row
    assign row[k] = STEP_MAP[k*NUM_UNITS +: NUM_UNITS];
  end

  always_comb begin
    member = '0;
    for (int k = 0; k < NUM_STEPS; k++) begin
      if (idx == IDX_W'(k)) member = row[k];
    end
  end

  assign in_prog = (idx < IDX_W'(NUM_STEPS));
endmodule

// File: rtl/seq_join_tracker.sv
module seq_join_tracker #(
  parameter int unsigned NUM_UNITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 capture,
  input  logic [NUM_UNITS-1:0] member,
  input  logic [NUM_UNITS-1:0] done_in,
  output logic [NUM_UNITS-1:0] flags,
  output logic                 all_done
);
  logic [NUM_UNITS-1:0] flags_d;
  logic                 flags_en;

  assign all_done = &(~member | flags | done_in);
  assign flags_en = clear | capture;

  always_comb begin
    flags_d = flags;
    if (clear)        flags_d = '0;
    else if (capture) flags_d = flags | (done_in & member);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags <= '0;
    else if (flags_en) flags <= flags_d;
  end

  // R4: a recorded completion is never lost until the step closes
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !clear) |=> ((($past(flags)) & ~flags) == '0));

  // R9: no completion is recorded for a unit outside the current step
  a_r9_member_only: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> ((flags & ~member) == '0));
endmodule

// File: rtl/seq_index_ctr.sv
module seq_index_ctr #(
  parameter int unsigned NUM_STEPS = 4,
  parameter int unsigned IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             advance,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] idx_d;
  logic             idx_en;

  assign idx_en = !run || advance;

  always_comb begin
    idx_d = idx;
    if (!run)         idx_d = '0;
    else if (advance) idx_d = idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx <= '0;
    else if (idx_en) idx <= idx_d;
  end

  // R3: an unfinished step keeps the index
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !advance) |=> $stable(idx));

  // R7: the index never passes the terminal value
  a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IDX_W'(NUM_STEPS));

  // R8: a low start returns the index to step 0
  a_r8_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (idx == '0));
endmodule

// File: rtl/hs_seq_ctrl.sv
module hs_seq_ctrl #(
  parameter int unsigned NUM_STEPS = 4,
  parameter int unsigned NUM_UNITS = 4,
  parameter logic [NUM_STEPS*NUM_UNITS-1:0] STEP_MAP = 16'h1A43
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 seq_go,
  input  logic [NUM_UNITS-1:0] unit_done,
  output logic [NUM_UNITS-1:0] unit_go,
  output logic                 seq_done
);
  import hs_seq_pkg::*;

  localparam int unsigned IDX_W = idx_width(NUM_STEPS);

  logic [IDX_W-1:0]     idx;
  logic [NUM_UNITS-1:0] member;
  logic [NUM_UNITS-1:0] flags;
  logic                 in_prog;
  logic                 all_done;
  logic                 active;
  logic                 advance;
  logic                 clear;

  assign active  = seq_go && in_prog;
  assign advance = active && all_done;
  assign clear   = !seq_go || advance;

  seq_step_decode #(
    .NUM_STEPS (NUM_STEPS),
    .NUM_UNITS (NUM_UNITS),
    .IDX_W     (IDX_W),
    .STEP_MAP  (STEP_MAP)
  ) u_decode (
    .idx     (idx),
    .member  (member),
    .in_prog (in_prog)
  );

  seq_join_tracker #(
    .NUM_UNITS (NUM_UNITS)
  ) u_join (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .capture  (active),
    .member   (member),
    .done_in  (unit_done),
    .flags    (flags),
    .all_done (all_done)
  );

  seq_index_ctr #(
    .NUM_STEPS (NUM_STEPS),
    .IDX_W     (IDX_W)
  ) u_index (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (seq_go),
    .advance (advance),
    .idx     (idx)
  );

  assign unit_go  = {NUM_UNITS{active}} & member & ~flags;
  assign seq_done = seq_go && (idx == IDX_W'(NUM_STEPS));

  // R5: a unit answered while the step still waits gets no go next cycle
  a_r5_go_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_go && !advance) |=> ((unit_go & $past(unit_go & unit_done)) == '0));

  // R7: completion and activation never overlap
  a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> (unit_go == '0));

  // R6: after a step closes, no member starts with a recorded completion
  a_r6_fresh_step: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (flags == '0));
endmodule

// File: tb/hs_seq_ctrl_bench.sv
`timescale 1ns/1ps
module hs_seq_ctrl_bench;
  localparam int NS = 4;
  localparam int NU = 4;
  localparam logic [NS*NU-1:0] MAP = 16'h1A43;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          seq_go;
  logic [NU-1:0] unit_done;
  logic [NU-1:0] unit_go;
  logic          seq_done;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // behavioural model state
  int            m_idx = 0;
  logic [NU-1:0] m_rec = '0;

  always #2 clk = ~clk;

  hs_seq_ctrl #(.NUM_STEPS(NS), .NUM_UNITS(NU), .STEP_MAP(MAP)) u_hs_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .seq_go(seq_go), .unit_done(unit_done),
    .unit_go(unit_go), .seq_done(seq_done));

  function automatic logic [NU-1:0] step_units(input int k);
    if (k < 0 || k >= NS) return '0;
    return MAP[k*NU +: NU];
  endfunction

  task automatic check(input string req, input logic [NU-1:0] act, input logic [NU-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // model advances on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_idx = 0; m_rec = '0;
    end else if (!seq_go) begin
      m_idx = 0; m_rec = '0;
    end else if (m_idx < NS) begin
      logic [NU-1:0] mem;
      mem = step_units(m_idx);
      if ((mem & ~(m_rec | unit_done)) == '0) begin
        m_idx = m_idx + 1; m_rec = '0;
      end else begin
        m_rec = m_rec | (unit_done & mem);
      end
    end
  end

  // drive one cycle, then compare against the model
  task automatic cyc(input logic g, input logic [NU-1:0] d);
    logic [NU-1:0] eg;
    @(negedge clk);
    seq_go = g; unit_done = d;
    #1;
    eg = (g && m_idx < NS) ? (step_units(m_idx) & ~m_rec) : '0;
    check("R2", unit_go, eg);
    check("R7", {{(NU-1){1'b0}}, seq_done}, {{(NU-1){1'b0}}, (g && m_idx == NS)});
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; seq_go = 1'b0; unit_done = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", unit_go, '0);
    @(negedge clk); rst_n = 1'b1;

    cyc(1, 4'b0000); check("R1", unit_go, 4'b0011);
    for (int i = 0; i < 5; i++) begin cyc(1, 4'b0000); check("R3", unit_go, 4'b0011); end
    cyc(1, 4'b0101); check("R2", unit_go, 4'b0011);
    cyc(1, 4'b0000); check("R5", unit_go, 4'b0010); check("R9", unit_go, 4'b0010);
    cyc(1, 4'b0010); check("R4", unit_go, 4'b0010);
    cyc(1, 4'b0000); check("R4", unit_go, 4'b0100);
    cyc(1, 4'b0100); check("R6", unit_go, 4'b0100);
    cyc(1, 4'b1010); check("R6", unit_go, 4'b1010);
    cyc(1, 4'b0001); check("R6", unit_go, 4'b0001);
    cyc(1, 4'b0000); check("R7", {3'b000, seq_done}, 4'b0001); check("R7", unit_go, 4'b0000);
    for (int i = 0; i < 3; i++) begin
      cyc(1, 4'b1111); check("R7", {3'b000, seq_done}, 4'b0001);
    end
    cyc(0, 4'b0000); check("R8", {unit_go[2:0], seq_done}, 4'b0000);
    cyc(1, 4'b0000); check("R8", unit_go, 4'b0011);

    for (int i = 0; i < 3000; i++) begin
      logic g;
      logic [NU-1:0] d;
      g = ($urandom_range(0, 39) != 0);
      for (int u = 0; u < NU; u++) d[u] = ($urandom_range(0, 3) == 0);
      cyc(g, d);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule